// File: doc/BRIEF.md
# Per-Bunch Occupancy Histogrammer

This block builds occupancy histograms of trigger activity, one histogram per monitored channel and one bin per bunch crossing of the machine orbit. A free-running bunch-crossing counter is pulled back to zero by an orbit marker and supplies the bin index. A small programmable stage chooses, for each monitored channel, which trigger input bit it follows and whether that bit is inverted. On every clock in which accumulation is running, each channel whose decoded bit is high adds one to the bin of the current bunch crossing.

Accumulation is a two-stage read-modify-write on a synchronous memory per channel. The most recent write is forwarded, so two updates to the same bin on consecutive clocks both count. Bins saturate at their all-ones value rather than wrap. With the default 30-bit bins, an input that is always on takes about a day to reach saturation. While accumulation is stopped, software reads single bins through a one-cycle read port, or starts a sweep that zeroes every bin of every channel at one address per clock and reports completion with a pulse.

Top module: `occ_hist_top`

## Requirements
- R1: After reset the bunch counter `bx_id` is 0. A high `orbit` sampled at a clock edge makes `bx_id` 0 after that edge.
- R2: Without `orbit`, `bx_id` advances by one per clock and goes from BUNCHES-1 to 0.
- R3: At each clock edge where `acc_en` is high and no clear is running, every channel whose decoded bit is 1 adds one to its bin whose index is the `bx_id` value shown before that edge.
- R4: The decoded bit of channel c is `trig_in[src[c]] XOR inv[c]`. After reset, src[c] = c mod N_IN and inv[c] = 0. A clock edge with `cfg_we` high loads `cfg_src` and `cfg_inv` into channel `cfg_chan`.
- R5: Updates to the same bin on consecutive clocks, such as orbit pulses on back-to-back clocks, are all counted.
- R6: A bin that holds 2^CNT_W-1 keeps that value when hit again.
- R7: With `acc_en` low and no clear running, a `rd_req` at an edge gives `rd_valid` high after that edge, with `rd_data` equal to bin `rd_bin` of channel `rd_chan`. A `rd_req` while `acc_en` is high leaves `rd_valid` low.
- R8: A `clr_start` with `acc_en` low starts a clear. `clr_busy` is then high for exactly BUNCHES clocks, every bin of every channel becomes 0, and `clr_done` pulses for one clock at the end. A `clr_start` while `acc_en` is high is ignored.
- R9: While `clr_busy` is high, no bin is incremented, whatever `acc_en` and `trig_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit | input | 1 | Orbit marker; forces the bunch counter to zero |
| trig_in | input | N_IN | Trigger input bits |
| acc_en | input | 1 | Accumulation enable |
| cfg_we | input | 1 | Write enable for the channel selection |
| cfg_chan | input | CH_W | Channel whose selection is written |
| cfg_src | input | SRC_W | Input index for that channel |
| cfg_inv | input | 1 | Inversion for that channel |
| rd_req | input | 1 | Bin read request |
| rd_chan | input | CH_W | Channel to read |
| rd_bin | input | BX_W | Bin to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Read bin value |
| clr_start | input | 1 | Start clearing all bins |
| clr_busy | output | 1 | Clear sweep in progress |
| clr_done | output | 1 | One-clock pulse at the end of a clear |
| bx_id | output | BX_W | Current bunch-crossing number |

## Verification
The assertions assume that software does not read while accumulation runs or a clear is in progress, and that `rd_chan` names an existing channel. They also assume that bins are cleared before they are trusted, because memory contents after reset are undefined. The stimulus clears first, lowers `acc_en` and idles two clocks before reading, so the last pending write has landed. Back-to-back orbit pulses, a held orbit and a narrow 3-bit bin width drive the forwarding and saturation paths within a short run.

// File: rtl/occ_hist_pkg.sv
package occ_hist_pkg;
  // Saturating increment on a 32-bit container.
  function automatic logic [31:0] sat_inc32(input logic [31:0] v, input logic [31:0] maxv);
    return (v >= maxv) ? maxv : v + 32'd1;
  endfunction

  // Next bunch number: orbit forces zero, last bunch wraps.
  function automatic logic [15:0] bx_next(input logic [15:0] cur, input logic [15:0] last,
                                          input logic orb);
    if (orb) return 16'd0;
    if (cur >= last) return 16'd0;
    return cur + 16'd1;
  endfunction
endpackage

// File: rtl/occ_bx_counter.sv
module occ_bx_counter #(
  parameter int BUNCHES = 3564,
  parameter int BX_W    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            orbit,
  output logic [BX_W-1:0] bx
);
  import occ_hist_pkg::*;
  localparam logic [BX_W-1:0] LAST = BX_W'(BUNCHES - 1);

  logic [BX_W-1:0] bx_q;
  logic [15:0]     nxt;

  assign nxt = bx_next(16'(bx_q), 16'(LAST), orbit);

  always_ff @(posedge clk) begin
    if (!rst_n) bx_q <= '0;
    else        bx_q <= nxt[BX_W-1:0];
  end

  assign bx = bx_q;

  p_orbit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    orbit |=> (bx == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!orbit && bx != LAST) |=> (bx == BX_W'($past(bx) + 1'b1)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!orbit && bx == LAST) |=> (bx == '0));
endmodule

// File: rtl/occ_input_select.sv
module occ_input_select #(
  parameter int N_IN  = 8,
  parameter int N_MON = 1,
  parameter int SRC_W = 3,
  parameter int CH_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  trig_in,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic             cfg_inv,
  output logic [N_MON-1:0] sel_bit
);
  logic [SRC_W-1:0] src_q [N_MON];
  logic             inv_q [N_MON];

  for (genvar c = 0; c < N_MON; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[c] <= SRC_W'(c % N_IN);
        inv_q[c] <= 1'b0;
      end else if (cfg_we && cfg_chan == CH_W'(c)) begin
        src_q[c] <= cfg_src;
        inv_q[c] <= cfg_inv;
      end
    end

    logic raw;
    always_comb begin
      raw = 1'b0;
      if (int'(src_q[c]) < N_IN) raw = trig_in[src_q[c]];
    end
    assign sel_bit[c] = raw ^ inv_q[c];

    p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_chan == CH_W'(c)) |=> (src_q[c] == $past(cfg_src) && inv_q[c] == $past(cfg_inv)));
  end
endmodule

// File: rtl/occ_hist_bank.sv
module occ_hist_bank #(
  parameter int BUNCHES = 3564,
  parameter int BX_W    = 12,
  parameter int CNT_W   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BX_W-1:0]  port_addr,
  input  logic             hit0,
  input  logic             clr_we,
  output logic [CNT_W-1:0] rd_q
);
  import occ_hist_pkg::*;
  localparam logic [31:0]      MAXV32 = (32'd1 << CNT_W) - 32'd1;
  localparam logic [CNT_W-1:0] MAXV   = CNT_W'(MAXV32);

  logic [CNT_W-1:0] mem [BUNCHES];
  logic [BX_W-1:0]  addr1;
  logic             hit1;
  logic [BX_W-1:0]  wr_addr_q;
  logic [CNT_W-1:0] wr_data_q;
  logic             wr_vld_q;

  // Named internal events for the checks.
  logic             fwd;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] upd;
  logic [31:0]      upd32;

  assign fwd   = wr_vld_q && (wr_addr_q == addr1);
  assign base  = fwd ? wr_data_q : rd_q;
  assign upd32 = sat_inc32(32'(base), MAXV32);
  assign upd   = upd32[CNT_W-1:0];

  always_ff @(posedge clk) begin
    rd_q <= mem[port_addr];
    if (clr_we) mem[port_addr] <= '0;
    else if (hit1) mem[addr1] <= upd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr1     <= '0;
      hit1      <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      wr_vld_q  <= 1'b0;
    end else begin
      addr1     <= port_addr;
      hit1      <= hit0 && !clr_we;
      wr_addr_q <= addr1;
      wr_data_q <= upd;
      wr_vld_q  <= hit1 && !clr_we;
    end
  end

  p_same_bin_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && fwd && wr_data_q != MAXV) |=> (wr_data_q == CNT_W'($past(wr_data_q) + 1'b1)));
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && fwd && wr_data_q == MAXV) |=> (wr_data_q == MAXV));
endmodule

// File: rtl/occ_hist_top.sv
module occ_hist_top #(
  parameter int N_IN    = 8,
  parameter int N_MON   = 1,
  parameter int BUNCHES = 3564,
  parameter int CNT_W   = 30,
  localparam int BX_W   = $clog2(BUNCHES),
  localparam int CH_W   = (N_MON > 1) ? $clog2(N_MON) : 1,
  localparam int SRC_W  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit,
  input  logic [N_IN-1:0]  trig_in,
  input  logic             acc_en,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic             cfg_inv,
  input  logic             rd_req,
  input  logic [CH_W-1:0]  rd_chan,
  input  logic [BX_W-1:0]  rd_bin,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  input  logic             clr_start,
  output logic             clr_busy,
  output logic             clr_done,
  output logic [BX_W-1:0]  bx_id
);
  localparam logic [BX_W-1:0] LAST = BX_W'(BUNCHES - 1);

  logic [BX_W-1:0]  bx;
  logic [N_MON-1:0] sel_bit;
  logic             active;
  logic [BX_W-1:0]  port_addr;
  logic [BX_W-1:0]  clr_cnt;
  logic             busy_q, done_q;
  logic             rd_vld_q;
  logic [CH_W-1:0]  rd_chan_q;
  logic [CNT_W-1:0] bank_q [N_MON];
  logic             clr_go;

  occ_bx_counter #(.BUNCHES(BUNCHES), .BX_W(BX_W)) u_bx (
    .clk(clk), .rst_n(rst_n), .orbit(orbit), .bx(bx));

  occ_input_select #(.N_IN(N_IN), .N_MON(N_MON), .SRC_W(SRC_W), .CH_W(CH_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_src(cfg_src), .cfg_inv(cfg_inv), .sel_bit(sel_bit));

  assign active = acc_en && !busy_q;
  assign clr_go = clr_start && !acc_en && !busy_q;

  always_comb begin
    if (active)      port_addr = bx;
    else if (busy_q) port_addr = clr_cnt;
    else             port_addr = rd_bin;
  end

  for (genvar c = 0; c < N_MON; c++) begin : g_bank
    occ_hist_bank #(.BUNCHES(BUNCHES), .BX_W(BX_W), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .port_addr(port_addr),
      .hit0(sel_bit[c] && active), .clr_we(busy_q), .rd_q(bank_q[c]));
  end

  // Clear sweep: one address per clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      clr_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (clr_go) begin
        busy_q  <= 1'b1;
        clr_cnt <= '0;
      end else if (busy_q) begin
        if (clr_cnt == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        clr_cnt <= clr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_chan_q <= '0;
    end else begin
      rd_vld_q  <= rd_req && !acc_en && !busy_q;
      rd_chan_q <= rd_chan;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < N_MON; c++)
      if (rd_chan_q == CH_W'(c)) rd_data = bank_q[c];
  end

  assign rd_valid = rd_vld_q;
  assign clr_busy = busy_q;
  assign clr_done = done_q;
  assign bx_id    = bx;

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_en) |=> !rd_valid);
  p_clr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !clr_busy) |=> !clr_busy);
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |-> ($past(clr_busy) && !clr_busy));
  p_busy_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (clr_cnt == BX_W'($past(clr_cnt) + 1'b1) || !clr_busy));
endmodule

// File: tb/tb_occ_hist_top.sv
`timescale 1ns/1ps
module tb_occ_hist_top;
  localparam int NI = 8, NM = 2, B = 12, W = 3;
  localparam int BXW = $clog2(B);
  localparam int MAXC = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic orbit = 0, acc_en = 0, cfg_we = 0, cfg_inv = 0, rd_req = 0, clr_start = 0;
  logic [NI-1:0] trig_in = '0;
  logic [0:0] cfg_chan = '0, rd_chan = '0;
  logic [2:0] cfg_src = '0;
  logic [BXW-1:0] rd_bin = '0;
  logic rd_valid, clr_busy, clr_done;
  logic [W-1:0] rd_data;
  logic [BXW-1:0] bx_id;

  int vecs = 0, errs = 0;
  int exp_bin [NM][B];
  int src_m [NM];
  int inv_m [NM];
  int bx_m = 0;
  bit in_clear = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  occ_hist_top #(.N_IN(NI), .N_MON(NM), .BUNCHES(B), .CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .orbit(orbit), .trig_in(trig_in), .acc_en(acc_en),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_src(cfg_src), .cfg_inv(cfg_inv),
    .rd_req(rd_req), .rd_chan(rd_chan), .rd_bin(rd_bin), .rd_valid(rd_valid),
    .rd_data(rd_data), .clr_start(clr_start), .clr_busy(clr_busy), .clr_done(clr_done),
    .bx_id(bx_id));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // One clock: inputs already driven at negedge; model the edge, return at next negedge.
  task automatic tick();
    @(posedge clk);
    if (acc_en && !in_clear)
      for (int c = 0; c < NM; c++)
        if ((trig_in[src_m[c]] ^ inv_m[c][0]) && exp_bin[c][bx_m] < MAXC)
          exp_bin[c][bx_m]++;
    if (cfg_we) begin
      src_m[cfg_chan] = int'(cfg_src);
      inv_m[cfg_chan] = int'(cfg_inv);
    end
    if (orbit) bx_m = 0;
    else bx_m = (bx_m == B - 1) ? 0 : bx_m + 1;
    @(negedge clk);
  endtask

  task automatic read_check(input int c, input int b, input string req);
    rd_req = 1; rd_chan = c[0:0]; rd_bin = BXW'(b);
    tick();
    rd_req = 0;
    check(rd_valid === 1'b1, req, int'(rd_valid), 1);
    check(int'(rd_data) == exp_bin[c][b], req, int'(rd_data), exp_bin[c][b]);
  endtask

  task automatic read_all(input string req);
    for (int c = 0; c < NM; c++)
      for (int b = 0; b < B; b++) read_check(c, b, req);
  endtask

  task automatic do_clear(input string req);
    int busy_n = 0, done_n = 0;
    clr_start = 1; in_clear = 1;
    tick();
    clr_start = 0;
    for (int i = 0; i < B + 4; i++) begin
      if (clr_busy) busy_n++;
      if (clr_done) done_n++;
      tick();
    end
    in_clear = 0;
    check(busy_n == B, req, busy_n, B);
    check(done_n == 1, req, done_n, 1);
    for (int c = 0; c < NM; c++)
      for (int b = 0; b < B; b++) exp_bin[c][b] = 0;
  endtask

  task automatic t_reset();
    check(bx_id == 0, "R1 reset bx", int'(bx_id), 0);
    check(rd_valid == 0, "R7 reset rd_valid", int'(rd_valid), 0);
    check(clr_busy == 0, "R8 reset busy", int'(clr_busy), 0);
    check(clr_done == 0, "R8 reset done", int'(clr_done), 0);
  endtask

  task automatic t_bunch_counter();
    for (int i = 0; i < 2 * B + 3; i++) begin
      tick();
      check(int'(bx_id) == bx_m, "R2 bx step/wrap", int'(bx_id), bx_m);
    end
    orbit = 1; tick(); orbit = 0;
    check(bx_id == 0, "R1 orbit zero", int'(bx_id), 0);
    tick();
    check(bx_id == 1, "R2 after orbit", int'(bx_id), 1);
  endtask

  task automatic accumulate(input int n, input int seed);
    acc_en = 1;
    for (int i = 0; i < n; i++) begin
      trig_in = NI'((i * 37 + seed) ^ (i >> 1));
      tick();
    end
    trig_in = '0; acc_en = 0;
    tick(); tick();
  endtask

  task automatic t_basic();
    do_clear("R8 clear sweep");
    read_all("R8 cleared zero");
    orbit = 1; tick(); orbit = 0;
    accumulate(30, 5);
    read_all("R3 accumulate default select");
  endtask

  task automatic t_select();
    do_clear("R8 clear sweep");
    cfg_we = 1; cfg_chan = 1'b0; cfg_src = 3'd5; cfg_inv = 0; tick();
    cfg_chan = 1'b1; cfg_src = 3'd2; cfg_inv = 1; tick();
    cfg_we = 0;
    accumulate(20, 11);
    read_all("R4 selection and inversion");
  endtask

  task automatic t_same_bin();
    do_clear("R8 clear sweep");
    acc_en = 1; trig_in = '1;
    orbit = 1; tick(); tick(); tick(); orbit = 0;
    tick();
    acc_en = 0; trig_in = '0; tick(); tick();
    read_check(0, 0, "R5 back-to-back same bin");
    read_check(1, 0, "R5 back-to-back same bin");
    read_check(0, 1, "R5 next bin");
  endtask

  task automatic t_saturate();
    do_clear("R8 clear sweep");
    acc_en = 1; trig_in = '1; orbit = 1;
    for (int i = 0; i < MAXC + 4; i++) tick();
    orbit = 0; acc_en = 0; trig_in = '0; tick(); tick();
    read_check(0, 0, "R6 saturate");
    check(exp_bin[0][0] == MAXC, "R6 model max", exp_bin[0][0], MAXC);
    read_check(1, 0, "R6 saturate");
  endtask

  task automatic t_ignored();
    acc_en = 1; rd_req = 1; rd_chan = 1'b0; rd_bin = '0;
    tick();
    rd_req = 0;
    check(rd_valid == 0, "R7 read ignored while enabled", int'(rd_valid), 0);
    clr_start = 1; tick(); clr_start = 0;
    check(clr_busy == 0, "R8 clear ignored while enabled", int'(clr_busy), 0);
    acc_en = 0; tick(); tick();
    read_check(0, 0, "R8 bins kept after ignored clear");
  endtask

  task automatic t_clear_blocks();
    clr_start = 1; in_clear = 1; tick(); clr_start = 0;
    acc_en = 1; trig_in = '1;
    for (int i = 0; i < B - 3; i++) tick();
    acc_en = 0; trig_in = '0;
    for (int i = 0; i < 6; i++) tick();
    in_clear = 0;
    for (int c = 0; c < NM; c++)
      for (int b = 0; b < B; b++) exp_bin[c][b] = 0;
    read_all("R9 no increment during clear");
  endtask

  initial begin
    for (int c = 0; c < NM; c++) begin
      src_m[c] = c % NI; inv_m[c] = 0;
      for (int b = 0; b < B; b++) exp_bin[c][b] = 0;
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    bx_m = 0;
    t_reset();
    t_bunch_counter();
    t_basic();
    t_select();
    t_same_bin();
    t_saturate();
    t_ignored();
    t_clear_blocks();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule